// File: doc/BRIEF.md
# External Edge Interrupt and Quasi-Bidirectional Port Group

This block serves a group of eight external pins. By default each pin is an interrupt input. Every pin passes through a two-stage synchronizer. A high-to-low change between two consecutive synchronized samples sets a sticky pending bit. That bit stays set until the CPU acknowledges that pin by index.

Software can move any pin into port mode through a mode register. In port mode the pin works as a quasi-bidirectional I/O bit:
- A 0 in the port register drives the pad strongly low.
- A 1 leaves only a weak pull-up, so an external source can pull the pad low and the pin acts as an input.

The bus side is a plain write strobe, an address and a combinational read. There are three registers: port, pad and mode. Each is split into a low half (pins 3..0) and a high half (pins 7..4), and each half has its own address. A write to the port address or to the pad address updates the same port register. A read of the port address returns the stored bits. A read of the pad address returns the synchronized pin levels.

Top module: `xint_port_group`

## Requirements
- R1: After reset the pending vector is 0, the port register is all ones, the mode register is all zeros (every pin in interrupt mode), no pin is driven low and every pin has its weak pull-up on.
- R2: A falling edge on a pin in interrupt mode sets that pin's pending bit. The bit is visible on the third rising clock edge after the pin falls, and not before.
- R3: A rising edge or a steady level on a pin never sets its pending bit.
- R4: A pending bit stays set until a cycle with `ack_valid_i` high and `ack_idx_i` equal to its pin number clears it. An acknowledge for any other index leaves it unchanged.
- R5: If a new edge is detected in the same cycle as the acknowledge for the same pin, the pending bit ends up set.
- R6: While a pin's mode bit is 1 (port mode), falling edges on that pin never set its pending bit.
- R7: Address decode on `addr_i` uses bit 0 for the half (0 = pins 3..0, 1 = pins 7..4) and bits 2..1 for the register (0 = port, 1 = pad, 2 = mode).
  - A write to either the port address or the pad address loads `wdata_i` into that half of the port register.
  - A read of the port address returns the stored bits.
  - Addresses 6 and 7 read 0, and writes to them are ignored.
- R8: A read of a pad address returns the pin levels after the two-stage synchronizer. This is two rising clock edges after the pins change.
- R9: A pin is driven strongly low (`pin_drive_low_o` = 1, `pin_weak_high_o` = 0) exactly when its mode bit is 1 and its port bit is 0. In every other case it shows only the weak pull-up.
- R10: Mode register halves are written and read back at their addresses. A mode bit of 1 selects port mode.
- R11: A write to one half of a register leaves the other half unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | 8 | Pad levels of the pins |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address (bit 0 selects the half) |
| wdata_i | input | 4 | Write data for one half |
| rd_data_o | output | 4 | Combinational read data for `addr_i` |
| ack_valid_i | input | 1 | Acknowledge strobe |
| ack_idx_i | input | 3 | Pin number being acknowledged |
| pending_o | output | 8 | Latched interrupt requests |
| pin_drive_low_o | output | 8 | Strong low enable per pin |
| pin_weak_high_o | output | 8 | Weak pull-up enable per pin |

## Verification
The assertions assume two things about the inputs:
- `ack_idx_i` is only meaningful while `ack_valid_i` is high.
- The edge detector's stored sample is reset high, so pins are taken to idle high from reset.

The stimulus respects both. Pins start high, and acknowledges are single-cycle strobes with an index below eight. Each pin change is held for at least three clock edges, so every edge gets through the synchronizer before the next change.

// File: rtl/xint_pkg.sv
package xint_pkg;
  localparam int unsigned ADDR_W = 3;

  // addr[2:1] register group, addr[0] half
  typedef enum logic [1:0] {
    GRP_PORT = 2'd0,
    GRP_PAD  = 2'd1,
    GRP_MODE = 2'd2,
    GRP_NONE = 2'd3
  } reg_grp_e;
endpackage

// File: rtl/xint_sync.sv
module xint_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  // reset high: pins idle high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '1;
      s2_q <= '1;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/xint_edge_latch.sv
module xint_edge_latch #(
  parameter int unsigned W     = 8,
  localparam int unsigned IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [W-1:0]     sync_i,
  input  logic [W-1:0]     mask_i,
  input  logic             ack_valid_i,
  input  logic [IDX_W-1:0] ack_idx_i,
  output logic [W-1:0]     fall_o,
  output logic [W-1:0]     pending_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '1;
    else         prev_q <= sync_i;
  end

  assign fall_o = prev_q & ~sync_i;

  for (genvar i = 0; i < W; i++) begin : g_pend
    logic set_w, clr_w;
    assign set_w = fall_o[i] & ~mask_i[i];
    assign clr_w = ack_valid_i && (ack_idx_i == IDX_W'(i));

    // set has priority over clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     pend_q[i] <= 1'b0;
      else if (set_w)  pend_q[i] <= 1'b1;
      else if (clr_w)  pend_q[i] <= 1'b0;
    end
  end

  assign pending_o = pend_q;
endmodule

// File: rtl/xint_port_regs.sv
module xint_port_regs
  import xint_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8,
  localparam int unsigned HALF_W  = NUM_PINS / 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [HALF_W-1:0]   wdata_i,
  input  logic [NUM_PINS-1:0] pad_i,
  output logic [NUM_PINS-1:0] port_o,
  output logic [NUM_PINS-1:0] mode_o,
  output logic [HALF_W-1:0]   rd_data_o
);
  reg_grp_e grp;
  logic [NUM_PINS-1:0] port_q, mode_q;

  assign grp = reg_grp_e'(addr_i[2:1]);

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic hit_w, port_we, mode_we;
    assign hit_w   = wr_en_i && (addr_i[0] == 1'(h));
    assign port_we = hit_w && (grp == GRP_PORT || grp == GRP_PAD);
    assign mode_we = hit_w && (grp == GRP_MODE);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        port_q[h*HALF_W +: HALF_W] <= '1;
        mode_q[h*HALF_W +: HALF_W] <= '0;
      end else begin
        if (port_we) port_q[h*HALF_W +: HALF_W] <= wdata_i;
        if (mode_we) mode_q[h*HALF_W +: HALF_W] <= wdata_i;
      end
    end
  end

  always_comb begin
    logic [NUM_PINS-1:0] src;
    unique case (grp)
      GRP_PORT: src = port_q;
      GRP_PAD:  src = pad_i;
      GRP_MODE: src = mode_q;
      default:  src = '0;
    endcase
    rd_data_o = addr_i[0] ? src[NUM_PINS-1:HALF_W] : src[HALF_W-1:0];
  end

  assign port_o = port_q;
  assign mode_o = mode_q;
endmodule

// File: rtl/xint_port_group.sv
module xint_port_group
  import xint_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8,
  localparam int unsigned HALF_W  = NUM_PINS / 2,
  localparam int unsigned IDX_W   = $clog2(NUM_PINS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [HALF_W-1:0]   wdata_i,
  output logic [HALF_W-1:0]   rd_data_o,
  input  logic                ack_valid_i,
  input  logic [IDX_W-1:0]    ack_idx_i,
  output logic [NUM_PINS-1:0] pending_o,
  output logic [NUM_PINS-1:0] pin_drive_low_o,
  output logic [NUM_PINS-1:0] pin_weak_high_o
);
  logic [NUM_PINS-1:0] pin_sync, fall_det, port_q, mode_q;

  xint_sync #(.W(NUM_PINS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  xint_edge_latch #(.W(NUM_PINS)) u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sync_i     (pin_sync),
    .mask_i     (mode_q),
    .ack_valid_i(ack_valid_i),
    .ack_idx_i  (ack_idx_i),
    .fall_o     (fall_det),
    .pending_o  (pending_o)
  );

  xint_port_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .pad_i    (pin_sync),
    .port_o   (port_q),
    .mode_o   (mode_q),
    .rd_data_o(rd_data_o)
  );

  // quasi-bidir: strong low only for a port-mode 0
  assign pin_drive_low_o = mode_q & ~port_q;
  assign pin_weak_high_o = ~pin_drive_low_o;
endmodule

// File: rtl/xint_port_group_chk.sv
module xint_port_group_chk #(
  parameter int unsigned NUM_PINS = 8,
  localparam int unsigned IDX_W   = $clog2(NUM_PINS)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                ack_valid_i,
  input logic [IDX_W-1:0]    ack_idx_i,
  input logic [NUM_PINS-1:0] pending_o,
  input logic [NUM_PINS-1:0] fall_det,
  input logic [NUM_PINS-1:0] mode_q,
  input logic [NUM_PINS-1:0] pin_drive_low_o,
  input logic [NUM_PINS-1:0] pin_weak_high_o
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
    assert_edge_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fall_det[i] && !mode_q[i]) |=> pending_o[i]);

    assert_no_spurious_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!pending_o[i] && !fall_det[i]) |=> !pending_o[i]);

    assert_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pending_o[i] && !(ack_valid_i && ack_idx_i == IDX_W'(i))) |=> pending_o[i]);

    assert_ack_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_valid_i && ack_idx_i == IDX_W'(i) && !fall_det[i]) |=> !pending_o[i]);

    assert_set_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_valid_i && ack_idx_i == IDX_W'(i) && fall_det[i] && !mode_q[i])
        |=> pending_o[i]);

    assert_port_masked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_q[i] && !pending_o[i]) |=> !pending_o[i]);

    assert_drive_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pin_drive_low_o[i] != pin_weak_high_o[i]);

    assert_low_needs_port_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pin_drive_low_o[i] |-> mode_q[i]);
  end
endmodule

bind xint_port_group xint_port_group_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .ack_valid_i    (ack_valid_i),
  .ack_idx_i      (ack_idx_i),
  .pending_o      (pending_o),
  .fall_det       (fall_det),
  .mode_q         (mode_q),
  .pin_drive_low_o(pin_drive_low_o),
  .pin_weak_high_o(pin_weak_high_o)
);

// File: tb/xint_port_group_bench.sv
module xint_port_group_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] pin_i = 8'hFF;
  logic       wr_en_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic [3:0] wdata_i = '0;
  logic [3:0] rd_data_o;
  logic       ack_valid_i = 1'b0;
  logic [2:0] ack_idx_i = '0;
  logic [7:0] pending_o, pin_drive_low_o, pin_weak_high_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  xint_port_group u_xint_port_group (
    .clk_i, .rst_ni, .pin_i, .wr_en_i, .addr_i, .wdata_i, .rd_data_o,
    .ack_valid_i, .ack_idx_i, .pending_o, .pin_drive_low_o, .pin_weak_high_o
  );

  // 0 pending, 1 rd_data, 2 drive_low, 3 weak_high
  typedef struct {
    int         sel;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t sb_q[$];

  always @(negedge clk_i) begin
    while (sb_q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = sb_q.pop_front();
      case (it.sel)
        0:       act = pending_o;
        1:       act = {4'h0, rd_data_o};
        2:       act = pin_drive_low_o;
        default: act = pin_weak_high_o;
      endcase
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, act, it.exp);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic push(input int sel, input logic [7:0] exp, input string tag);
    item_t it;
    it.sel = sel; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic exp_rd(input logic [2:0] a, input logic [3:0] exp, input string tag);
    addr_i = a;
    push(1, {4'h0, exp}, tag);
  endtask

  task automatic settle();
    @(negedge clk_i);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [3:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    tick(1);
    wr_en_i = 1'b0;
  endtask

  task automatic ack(input logic [2:0] idx);
    ack_valid_i = 1'b1; ack_idx_i = idx;
    tick(1);
    ack_valid_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_ni = 1'b1;
    tick(1);

    // R1 reset state
    push(0, 8'h00, "R1 pending"); push(2, 8'h00, "R1 drive_low");
    push(3, 8'hFF, "R1 weak_high"); exp_rd(3'd0, 4'hF, "R1 port lo"); settle();
    exp_rd(3'd5, 4'h0, "R1 mode hi"); settle();

    // R2 / R8: pin 2 falls
    pin_i = 8'hFB;
    tick(2);
    push(0, 8'h00, "R2 not yet"); exp_rd(3'd2, 4'hB, "R8 pad lo"); settle();
    tick(1);
    push(0, 8'h04, "R2 pending pin2"); settle();

    // R3 rising edge and steady level
    pin_i = 8'hFF;
    tick(4);
    push(0, 8'h04, "R3 rise no effect"); settle();

    // R4 wrong index, then right index
    ack(3'd5);
    push(0, 8'h04, "R4 other ack"); settle();
    ack(3'd2);
    push(0, 8'h00, "R4 ack clears"); settle();

    // R5 edge and ack same cycle
    pin_i = 8'hBF;
    tick(2);
    ack(3'd6);
    push(0, 8'h40, "R5 set wins"); settle();
    pin_i = 8'hFF;
    tick(3);
    ack(3'd6);
    push(0, 8'h00, "R5 cleanup"); settle();

    // R10 / R6: pin 0 to port mode
    wr(3'd4, 4'h1);
    exp_rd(3'd4, 4'h1, "R10 mode lo"); settle();
    pin_i = 8'hFC;
    tick(4);
    push(0, 8'h02, "R6 port pin masked"); settle();
    pin_i = 8'hFF;
    tick(3);
    ack(3'd1);

    // R7 / R9 port register writes
    wr(3'd0, 4'hE);
    exp_rd(3'd0, 4'hE, "R7 port lo read"); push(2, 8'h01, "R9 drive low pin0");
    push(3, 8'hFE, "R9 weak pin0 off"); settle();
    wr(3'd2, 4'hF);
    exp_rd(3'd0, 4'hF, "R7 write via pad addr"); push(2, 8'h00, "R9 released"); settle();

    // R11 halves independent; R9 interrupt-mode pins never driven low
    wr(3'd1, 4'h5);
    exp_rd(3'd0, 4'hF, "R11 lo kept"); push(2, 8'h00, "R9 int mode no drive"); settle();
    exp_rd(3'd1, 4'h5, "R11 hi written"); settle();
    wr(3'd5, 4'hF);
    push(2, 8'hA0, "R9 hi drive"); push(3, 8'h5F, "R9 hi weak");
    exp_rd(3'd4, 4'h1, "R11 mode lo kept"); settle();

    // R7 unused address
    wr(3'd7, 4'h0);
    exp_rd(3'd7, 4'h0, "R7 unused reads 0"); settle();
    exp_rd(3'd0, 4'hF, "R7 unused write ignored"); settle();
    exp_rd(3'd1, 4'h5, "R7 unused write ignored hi"); settle();

    // R8 pad read, R6 for port pins in high half
    pin_i = 8'h3C;
    tick(2);
    exp_rd(3'd2, 4'hC, "R8 pad lo"); settle();
    exp_rd(3'd3, 4'h3, "R8 pad hi"); settle();
    tick(2);
    push(0, 8'h02, "R6 only int pin1 pends"); settle();

    settle();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule